// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block collects single-cycle event pulses from eight peripheral sources into one 8-bit flag register and turns them into a single interrupt request. Six flags are sticky: hardware raises them on an event and only a software write brings them back down. The other two are live status bits that follow whether the serial receive buffer holds data and whether the serial transmit buffer is empty. They change only through the side effects of the data-register accesses reported on dedicated pins.

A second 8-bit register holds a per-flag enable. The interrupt request is the global enable ANDed with the OR of all enabled flags. Both registers share a plain one-cycle register port. A write takes effect at the clock edge. Read data is combinational from the current state and the selected address. There is no data stream here, so the port has no valid/ready handshake and never applies back-pressure. Every access completes in the cycle it is presented.

Top module: `pir_flag_block`

## Requirements
- R1: Address 0 reads the flag register with this layout: bit 7 timer1 gate, bit 6 ADC done, bit 5 receive full, bit 4 transmit empty, bit 3 sync serial done, bit 2 capture/compare, bit 1 timer2 period match, bit 0 timer1 overflow. Address 1 reads the enable register.
- R2: A writable flag (bits 7, 6, 3, 2, 1, 0) goes to 1 in the cycle after its event pulse and stays 1 until a software write clears it.
- R3: A write to address 0 loads each writable flag from the write data. A 0 clears the flag and a 1 sets it.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R5: Bits 5 and 4 are read-only. Writes to address 0 leave them unchanged.
- R6: The receive-full bit goes to 1 after a buffer load pulse and to 0 after a receive data read pulse. A load wins when both occur in the same cycle.
- R7: The transmit-empty bit goes to 0 after a transmit data write pulse and to 1 after a drain pulse. A drain wins when both occur in the same cycle.
- R8: After reset the writable flags and the enable register are 0, receive-full is 0, transmit-empty is 1, and the interrupt request is 0.
- R9: Flags are set by their events whatever the values of the enable register and the global enable.
- R10: The capture/compare flag is set by the capture pulse when the mode is 2'b00, and by the compare pulse when the mode is 2'b01. In modes 2'b10 and 2'b11 it is never set by either pulse.
- R11: The interrupt request equals the global enable ANDed with the OR over all bits of (flag AND enable).
- R12: A write to address 1 loads the enable register with all 8 bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | 0 = flag register, 1 = enable register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ev_gate | input | 1 | Timer1 gate event pulse |
| ev_adc | input | 1 | ADC conversion done pulse |
| ev_ssp | input | 1 | Sync serial transfer done pulse |
| ev_cap | input | 1 | Capture event pulse |
| ev_cmp | input | 1 | Compare match pulse |
| ccp_mode | input | 2 | 00 capture, 01 compare, 1x PWM |
| ev_t2match | input | 1 | Timer2 period match pulse |
| ev_t1ovf | input | 1 | Timer1 overflow pulse |
| rx_load | input | 1 | Receive buffer loaded |
| rx_read | input | 1 | Receive data register read |
| tx_write | input | 1 | Transmit data register written |
| tx_drain | input | 1 | Transmit buffer moved out, now empty |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The main function is tried with sparse random event pulses mixed with random register writes, so flags build up and then get cleared in many orders. Directed cases pit an event against a clearing write in the same cycle, a load against a read, and a drain against a write, which separates set-wins ordering from plain priority errors. PWM mode pulses and writes aimed at the read-only bits show whether gating and masking hold. Random global enable and enable masks, checked against the interrupt output, separate a correct AND-OR combine from one that ignores the enables or the global gate.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned BIT_T1OVF = 0;
  localparam int unsigned BIT_T2M   = 1;
  localparam int unsigned BIT_CCP   = 2;
  localparam int unsigned BIT_SSP   = 3;
  localparam int unsigned BIT_TXE   = 4;
  localparam int unsigned BIT_RXF   = 5;
  localparam int unsigned BIT_ADC   = 6;
  localparam int unsigned BIT_GATE  = 7;

  // Bits software may write; the rest are live status.
  localparam logic [REG_W-1:0] WR_MASK = 8'b1100_1111;

  typedef enum logic [1:0] {
    CCP_CAPTURE = 2'b00,
    CCP_COMPARE = 2'b01,
    CCP_PWM_A   = 2'b10,
    CCP_PWM_B   = 2'b11
  } ccp_mode_e;

  localparam logic ADDR_FLAGS  = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;
endpackage

// File: rtl/pir_sticky_flags.sv
module pir_sticky_flags #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hw_set,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_data,
  output logic [W-1:0] flags_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)
          flags_q[i] <= 1'b0;
        else if (hw_set[i])
          flags_q[i] <= 1'b1;        // event beats any write
        else if (sw_wr)
          flags_q[i] <= sw_data[i];
      end
    end else begin : g_none
      assign flags_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pir_status_bit.sv
module pir_status_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= RST_VAL;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/pir_irq_combine.sv
module pir_irq_combine #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] flags,
  input  logic [W-1:0] enables,
  input  logic         gie,
  output logic         irq
);
  logic [W-1:0] hit;
  assign hit = flags & enables;
  assign irq = gie & (|hit);
endmodule

// File: rtl/pir_flag_block.sv
module pir_flag_block
  import pir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ev_gate,
  input  logic             ev_adc,
  input  logic             ev_ssp,
  input  logic             ev_cap,
  input  logic             ev_cmp,
  input  logic [1:0]       ccp_mode,
  input  logic             ev_t2match,
  input  logic             ev_t1ovf,
  input  logic             rx_load,
  input  logic             rx_read,
  input  logic             tx_write,
  input  logic             tx_drain,
  input  logic             gie,
  output logic             irq
);
  logic             ccp_evt;
  logic [REG_W-1:0] hw_set;
  logic [REG_W-1:0] sticky_q;
  logic [REG_W-1:0] flags;
  logic [REG_W-1:0] enable_q;
  logic             rx_full, tx_empty;
  logic             wr_flags, wr_enable;

  assign wr_flags  = reg_wr && (reg_addr == ADDR_FLAGS);
  assign wr_enable = reg_wr && (reg_addr == ADDR_ENABLE);

  always_comb begin
    unique case (ccp_mode_e'(ccp_mode))
      CCP_CAPTURE: ccp_evt = ev_cap;
      CCP_COMPARE: ccp_evt = ev_cmp;
      default:     ccp_evt = 1'b0;
    endcase
  end

  always_comb begin
    hw_set            = '0;
    hw_set[BIT_GATE]  = ev_gate;
    hw_set[BIT_ADC]   = ev_adc;
    hw_set[BIT_SSP]   = ev_ssp;
    hw_set[BIT_CCP]   = ccp_evt;
    hw_set[BIT_T2M]   = ev_t2match;
    hw_set[BIT_T1OVF] = ev_t1ovf;
  end

  pir_sticky_flags #(.W(REG_W), .MASK(WR_MASK)) u_sticky (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set),
    .sw_wr(wr_flags), .sw_data(reg_wdata), .flags_q(sticky_q)
  );

  pir_status_bit #(.RST_VAL(1'b0)) u_rxf (
    .clk(clk), .rst_n(rst_n), .set_i(rx_load), .clr_i(rx_read), .q(rx_full)
  );

  pir_status_bit #(.RST_VAL(1'b1)) u_txe (
    .clk(clk), .rst_n(rst_n), .set_i(tx_drain), .clr_i(tx_write), .q(tx_empty)
  );

  always_comb begin
    flags          = sticky_q;
    flags[BIT_RXF] = rx_full;
    flags[BIT_TXE] = tx_empty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         enable_q <= '0;
    else if (wr_enable) enable_q <= reg_wdata;
  end

  assign reg_rdata = (reg_addr == ADDR_ENABLE) ? enable_q : flags;

  pir_irq_combine #(.W(REG_W)) u_irq (
    .flags(flags), .enables(enable_q), .gie(gie), .irq(irq)
  );
endmodule

// File: rtl/pir_flag_block_checker.sv
module pir_flag_block_checker
  import pir_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_addr,
  input logic             reg_wr,
  input logic [REG_W-1:0] hw_set,
  input logic [REG_W-1:0] flags,
  input logic [1:0]       ccp_mode,
  input logic             rx_load,
  input logic             rx_read,
  input logic             tx_write,
  input logic             tx_drain,
  input logic             gie,
  input logic             irq
);
  logic wr_f;
  assign wr_f = reg_wr && (reg_addr == ADDR_FLAGS);

  // R2: without a flag write, set sticky flags stay set
  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_f |=> ((flags & WR_MASK & $past(flags)) == ($past(flags) & WR_MASK)));

  // R4: every event lands even under a write
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((flags & $past(hw_set)) == $past(hw_set)));

  // R6: load wins over read
  p_rx_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> flags[BIT_RXF]);

  // R7: write without drain empties nothing
  p_tx_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write && !tx_drain) |=> !flags[BIT_TXE]);

  // R5: flag writes do not move the status bits
  p_ro_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_f && !rx_load && !rx_read && !tx_write && !tx_drain)
      |=> (flags[BIT_RXF] == $past(flags[BIT_RXF]) &&
           flags[BIT_TXE] == $past(flags[BIT_TXE])));

  // R10: PWM modes never raise the capture/compare flag
  p_pwm_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ccp_mode[1] && !wr_f && !flags[BIT_CCP]) |=> !flags[BIT_CCP]);

  // R11: global enable low masks the request
  p_gie_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);
endmodule

bind pir_flag_block pir_flag_block_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .hw_set(hw_set), .flags(flags), .ccp_mode(ccp_mode),
  .rx_load(rx_load), .rx_read(rx_read), .tx_write(tx_write),
  .tx_drain(tx_drain), .gie(gie), .irq(irq)
);

// File: tb/pir_flag_block_test.sv
module pir_flag_block_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_addr = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       ev_gate = 0, ev_adc = 0, ev_ssp = 0, ev_cap = 0, ev_cmp = 0;
  logic [1:0] ccp_mode = 2'b00;
  logic       ev_t2match = 0, ev_t1ovf = 0;
  logic       rx_load = 0, rx_read = 0, tx_write = 0, tx_drain = 0;
  logic       gie = 0, irq;

  int tests = 0, fails = 0;
  logic [7:0] m_flags, m_en;

  always #4 clk = ~clk;

  pir_flag_block uut (.*);

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [7:0] next_flags(logic [7:0] cur);
    logic [7:0] hw, r;
    logic ccp;
    ccp = (ccp_mode == 2'b00) ? ev_cap : (ccp_mode == 2'b01) ? ev_cmp : 1'b0;
    hw = {ev_gate, ev_adc, 2'b00, ev_ssp, ccp, ev_t2match, ev_t1ovf};
    r = (reg_wr && !reg_addr) ? ((reg_wdata & 8'hCF) | hw) : ((cur & 8'hCF) | hw);
    r[5] = rx_load ? 1'b1 : rx_read ? 1'b0 : cur[5];
    r[4] = tx_drain ? 1'b1 : tx_write ? 1'b0 : cur[4];
    return r;
  endfunction

  function automatic logic exp_irq(logic [7:0] f, logic [7:0] e, logic g);
    return g & (|(f & e));
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    reg_wr = 0; reg_wdata = '0;
    ev_gate = 0; ev_adc = 0; ev_ssp = 0; ev_cap = 0; ev_cmp = 0;
    ev_t2match = 0; ev_t1ovf = 0;
    rx_load = 0; rx_read = 0; tx_write = 0; tx_drain = 0;
  endtask

  // Apply current inputs over one edge, update model, check at negedge.
  task automatic step(string tag);
    @(posedge clk);
    m_flags = next_flags(m_flags);
    if (reg_wr && reg_addr) m_en = reg_wdata;
    @(negedge clk);
    chk(tag, reg_rdata, reg_addr ? m_en : m_flags);
    chk({tag, " irq R11"}, {7'd0, irq}, {7'd0, exp_irq(m_flags, m_en, gie)});
    clear_in();
  endtask

  task automatic peek(string tag, logic a);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, a ? m_en : m_flags);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_flags = 8'h10; m_en = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R8 reset irq", {7'd0, irq}, 8'h00);
    peek("R8 reset flags", 1'b0);
    peek("R8 reset enables", 1'b1);

    // R12 enable write, R1 readback
    reg_addr = 1; reg_wr = 1; reg_wdata = 8'hA5; step("R12 enable write");
    reg_addr = 1; reg_wr = 1; reg_wdata = 8'h00; step("R12 enable clear");

    // R9: events with enables and gie off
    reg_addr = 0; ev_gate = 1; ev_t1ovf = 1; step("R9 set with enables off");
    // R1: each source lands on its own bit
    ev_adc = 1; step("R1 adc bit6");
    ev_ssp = 1; step("R1 ssp bit3");
    ev_t2match = 1; step("R1 t2 bit1");
    step("R2 flags hold");
    // R3: write 0 clears
    reg_wr = 1; reg_wdata = 8'h00; step("R3 write zero clears");
    // R3: write 1 sets, R5 read-only bits untouched
    reg_wr = 1; reg_wdata = 8'hFF; step("R3 write one sets / R5");
    // R4: event and clear together
    reg_wr = 1; reg_wdata = 8'h00; ev_adc = 1; ev_t1ovf = 1; step("R4 set wins");
    reg_wr = 1; reg_wdata = 8'h00; step("R4 cleanup");
    // R10 modes
    ccp_mode = 2'b00; ev_cap = 1; step("R10 capture mode");
    reg_wr = 1; reg_wdata = 8'h00; step("R10 clear");
    ccp_mode = 2'b00; ev_cmp = 1; step("R10 capture ignores compare");
    ccp_mode = 2'b01; ev_cmp = 1; step("R10 compare mode");
    reg_wr = 1; reg_wdata = 8'h00; step("R10 clear2");
    ccp_mode = 2'b10; ev_cap = 1; ev_cmp = 1; step("R10 pwm 10");
    ccp_mode = 2'b11; ev_cap = 1; ev_cmp = 1; step("R10 pwm 11");
    // R6/R7 status bits
    rx_load = 1; step("R6 rx load");
    reg_wr = 1; reg_wdata = 8'h00; step("R5 write leaves rx full");
    rx_read = 1; step("R6 rx read");
    rx_load = 1; rx_read = 1; step("R6 load wins");
    tx_write = 1; step("R7 tx write");
    reg_wr = 1; reg_wdata = 8'h30; step("R5 write leaves tx");
    tx_drain = 1; tx_write = 1; step("R7 drain wins");
    // R11 directed
    reg_addr = 1; reg_wr = 1; reg_wdata = 8'h20; gie = 1; step("R11 rx enabled");
    gie = 0; step("R11 gie off");

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      reg_addr   = $urandom_range(0, 1);
      reg_wr     = ($urandom_range(0, 3) == 0);
      reg_wdata  = 8'($urandom);
      ev_gate    = ($urandom_range(0, 9) == 0);
      ev_adc     = ($urandom_range(0, 9) == 0);
      ev_ssp     = ($urandom_range(0, 9) == 0);
      ev_cap     = ($urandom_range(0, 7) == 0);
      ev_cmp     = ($urandom_range(0, 7) == 0);
      ccp_mode   = 2'($urandom);
      ev_t2match = ($urandom_range(0, 9) == 0);
      ev_t1ovf   = ($urandom_range(0, 9) == 0);
      rx_load    = ($urandom_range(0, 5) == 0);
      rx_read    = ($urandom_range(0, 5) == 0);
      tx_write   = ($urandom_range(0, 5) == 0);
      tx_drain   = ($urandom_range(0, 5) == 0);
      gie        = $urandom_range(0, 1);
      step("R2 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule